// File: doc/BRIEF.md
# Host Memory Address Decode Router

This block sits on the host side of a memory controller and decides where each host memory transaction goes. A request comes with an address that is wider than 32 bits and a read/write flag. One clock after the request strobe, the block presents a registered one-hot target select. The four targets are system DRAM, the graphics port, the downstream hub/PCI port, and local completion. A forwarded request carries only the low 32 bits of the address, because neither downstream port can take a wider address. Any access at or above 4 GB is completed by the block itself. Reads get all-zero data and writes are dropped.

Below 1 MB, the conventional area is DRAM and the VGA window is steered by a control bit. The area above the VGA window is cut into equal segments, and each segment has a two-bit attribute that steers reads and writes separately. Above 1 MB, a top-of-memory register splits DRAM from device space. A graphics aperture base/limit pair carves a window out of that device space. Configuration software programs these through a small register write port. The block does not check programmed ranges for overlap. Software must keep them disjoint and must leave room for device windows below 4 GB.

Top module: `host_addr_router`

## Requirements
- R1: `tgt_valid` is high in exactly the cycle after each cycle with `req_valid` high. While it is high, `tgt_sel` is one-hot: bit 0 is DRAM, bit 1 is graphics, bit 2 is hub, bit 3 is local. With `req_valid` low, `tgt_sel`, `tgt_addr` and `tgt_write` hold their values.
- R2: A request whose address bits above bit 31 are not all zero is routed local (`tgt_sel` = 4'b1000) with `tgt_addr` = 0, whatever its low bits are.
- R3: A local read raises `loc_rsp_valid` in the result cycle with `loc_rsp_data` all zeros. A local write raises no response and is not forwarded.
- R4: A request below 4 GB is forwarded with `tgt_addr` equal to its low 32 bits, and `tgt_write` equal to its write flag.
- R5: Addresses 00000h to 9FFFFh go to DRAM for reads and writes.
- R6: The VGA window A0000h to BFFFFh goes to graphics when control register bit 0 is 1, and to the hub when it is 0.
- R7: From C0000h up, 16 KB segment i starts at C0000h + i*4000h (i = 0..15). Its attribute is bits [2i+1:2i] of the segment register. Bit 2i sends reads to DRAM and bit 2i+1 sends writes to DRAM, so 00 is disabled, 01 read-only, 10 write-only and 11 read/write. A direction whose bit is clear goes to the hub.
- R8: Addresses from 1 MB up to, but not including, the top-of-memory value go to DRAM.
- R9: Addresses from top-of-memory to below 4 GB go to graphics when they lie inside the aperture [base, limit], both ends included, and to the hub otherwise. The aperture is empty when base > limit.
- R10: A write on the config port with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_sel`: 0 top-of-memory, 1 aperture base, 2 aperture limit, 3 control, 4 segment attributes. The value applies from the next cycle. Codes 5 to 7, and cycles with `cfg_we` low, change nothing.
- R11: After reset, top-of-memory is 0010_0000h, aperture base is FFFF_FFFFh, aperture limit is 0, and control and segment attributes are 0. `tgt_valid` and `loc_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request strobe |
| req_addr | input | HADDR_W (36) | Host physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Config register write enable |
| cfg_sel | input | 3 | Config register select |
| cfg_wdata | input | 32 | Config write data |
| tgt_valid | output | 1 | Routing result valid |
| tgt_sel | output | 4 | One-hot target: DRAM, graphics, hub, local |
| tgt_addr | output | 32 | Address to forward (0 when local) |
| tgt_write | output | 1 | Direction of the routed request |
| loc_rsp_valid | output | 1 | Locally completed read response |
| loc_rsp_data | output | DATA_W (64) | Read data of a local completion (zero) |

## Verification
The bench probes every range edge on both sides: 9FFFFh against A0000h, BFFFFh against C0000h, the last byte of a segment, top-of-memory minus one against top-of-memory, and both aperture ends. An off-by-one compare would route one of these to the wrong port. Each segment attribute is tested in both directions, so a decoder that swapped the read and write bits would send writes to DRAM for a read-only segment. Above 4 GB, the bench uses addresses whose low 32 bits would otherwise hit DRAM. A router that truncated the address first would leak such accesses downstream, and one that answered writes would raise a spurious response. Config writes with unused select codes, or with the enable low, are followed by requests that expose any register they might have corrupted.

// File: rtl/hr_pkg.sv
package hr_pkg;
  localparam int CFG_W = 32;

  typedef enum logic [1:0] {
    TGT_DRAM  = 2'd0,
    TGT_GFX   = 2'd1,
    TGT_HUB   = 2'd2,
    TGT_LOCAL = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    CSEL_TOM   = 3'd0,
    CSEL_APB   = 3'd1,
    CSEL_APL   = 3'd2,
    CSEL_CTRL  = 3'd3,
    CSEL_SEG   = 3'd4
  } csel_e;

  typedef struct packed {
    logic [31:0] tom;
    logic [31:0] ap_base;
    logic [31:0] ap_limit;
    logic        vga_gfx;
  } cfg_t;

  localparam logic [19:0] VGA_LO = 20'hA0000;
  localparam logic [19:0] VGA_HI = 20'hBFFFF;

  localparam logic [31:0] TOM_RST   = 32'h0010_0000;
  localparam logic [31:0] APB_RST   = 32'hFFFF_FFFF;
  localparam logic [31:0] APL_RST   = 32'h0000_0000;
endpackage

// File: rtl/hr_rst_sync.sv
module hr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/hr_cfg_regs.sv
module hr_cfg_regs
  import hr_pkg::*;
#(
  parameter int SEG_COUNT = 16,
  localparam int ATTR_W = 2 * SEG_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output cfg_t              cfg,
  output logic [ATTR_W-1:0] seg_attr
);
  cfg_t              cfg_q, cfg_d;
  logic [ATTR_W-1:0] attr_q, attr_d;

  always_comb begin
    cfg_d  = cfg_q;
    attr_d = attr_q;
    if (cfg_we) begin
      case (cfg_sel)
        CSEL_TOM:  cfg_d.tom      = cfg_wdata;
        CSEL_APB:  cfg_d.ap_base  = cfg_wdata;
        CSEL_APL:  cfg_d.ap_limit = cfg_wdata;
        CSEL_CTRL: cfg_d.vga_gfx  = cfg_wdata[0];
        CSEL_SEG:  attr_d         = cfg_wdata[ATTR_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.tom      <= TOM_RST;
      cfg_q.ap_base  <= APB_RST;
      cfg_q.ap_limit <= APL_RST;
      cfg_q.vga_gfx  <= 1'b0;
      attr_q         <= '0;
    end else begin
      cfg_q  <= cfg_d;
      attr_q <= attr_d;
    end
  end

  assign cfg      = cfg_q;
  assign seg_attr = attr_q;
endmodule

// File: rtl/hr_legacy_decode.sv
module hr_legacy_decode
  import hr_pkg::*;
#(
  parameter int          SEG_COUNT = 16,
  parameter int          SEG_LG2   = 14,
  parameter logic [19:0] SEG_BASE  = 20'hC0000,
  localparam int ATTR_W = 2 * SEG_COUNT,
  localparam int IDX_W  = 20 - SEG_LG2
) (
  input  logic [19:0]       addr,
  input  logic              write,
  input  logic              vga_gfx,
  input  logic [ATTR_W-1:0] seg_attr,
  output tgt_e              tgt
);
  localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(SEG_BASE >> SEG_LG2);

  logic [SEG_COUNT-1:0] seg_hit;
  logic [SEG_COUNT-1:0] seg_dram;

  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
    logic [1:0] attr;
    assign attr        = seg_attr[2*i +: 2];
    assign seg_hit[i]  = (addr[19:SEG_LG2] == BASE_IDX + IDX_W'(i));
    assign seg_dram[i] = write ? attr[1] : attr[0];
  end

  always_comb begin
    if (addr < VGA_LO)       tgt = TGT_DRAM;
    else if (addr <= VGA_HI) tgt = vga_gfx ? TGT_GFX : TGT_HUB;
    else if (|seg_hit)       tgt = (|(seg_hit & seg_dram)) ? TGT_DRAM : TGT_HUB;
    else                     tgt = TGT_HUB;
  end
endmodule

// File: rtl/hr_high_decode.sv
module hr_high_decode
  import hr_pkg::*;
(
  input  logic [31:0] addr,
  input  cfg_t        cfg,
  output tgt_e        tgt
);
  logic below_tom;
  logic in_aper;

  assign below_tom = addr < cfg.tom;
  assign in_aper   = (addr >= cfg.ap_base) && (addr <= cfg.ap_limit);

  always_comb begin
    if (below_tom)    tgt = TGT_DRAM;
    else if (in_aper) tgt = TGT_GFX;
    else              tgt = TGT_HUB;
  end
endmodule

// File: rtl/host_addr_router.sv
module host_addr_router
  import hr_pkg::*;
#(
  parameter int HADDR_W   = 36,
  parameter int DATA_W    = 64,
  parameter int SEG_COUNT = 16,
  parameter int SEG_LG2   = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic               req_write,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic               tgt_valid,
  output logic [3:0]         tgt_sel,
  output logic [31:0]        tgt_addr,
  output logic               tgt_write,
  output logic               loc_rsp_valid,
  output logic [DATA_W-1:0]  loc_rsp_data
);
  localparam int ATTR_W = 2 * SEG_COUNT;
  localparam int HI_W   = HADDR_W - 32;

  logic              rst_q_n;
  cfg_t              cfg;
  logic [ATTR_W-1:0] seg_attr;
  tgt_e              low_tgt, high_tgt, route;
  logic              above_4g, below_1m;

  hr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  hr_cfg_regs #(.SEG_COUNT(SEG_COUNT)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg       (cfg),
    .seg_attr  (seg_attr)
  );

  hr_legacy_decode #(.SEG_COUNT(SEG_COUNT), .SEG_LG2(SEG_LG2)) u_low (
    .addr     (req_addr[19:0]),
    .write    (req_write),
    .vga_gfx  (cfg.vga_gfx),
    .seg_attr (seg_attr),
    .tgt      (low_tgt)
  );

  hr_high_decode u_high (
    .addr (req_addr[31:0]),
    .cfg  (cfg),
    .tgt  (high_tgt)
  );

  assign above_4g = |req_addr[HADDR_W-1:32];
  assign below_1m = ~|req_addr[31:20];

  always_comb begin
    if (above_4g)      route = TGT_LOCAL;
    else if (below_1m) route = low_tgt;
    else               route = high_tgt;
  end

  // next-state for the result register
  logic        valid_d, write_d, rsp_d;
  logic [3:0]  sel_d;
  logic [31:0] addr_d;

  always_comb begin
    valid_d = req_valid;
    rsp_d   = req_valid && (route == TGT_LOCAL) && !req_write;
    sel_d   = tgt_sel;
    addr_d  = tgt_addr;
    write_d = tgt_write;
    if (req_valid) begin
      sel_d   = 4'b0001 << route;
      addr_d  = (route == TGT_LOCAL) ? 32'h0 : req_addr[31:0];
      write_d = req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      tgt_valid     <= 1'b0;
      loc_rsp_valid <= 1'b0;
      tgt_sel       <= 4'b0000;
      tgt_addr      <= 32'h0;
      tgt_write     <= 1'b0;
    end else begin
      tgt_valid     <= valid_d;
      loc_rsp_valid <= rsp_d;
      tgt_sel       <= sel_d;
      tgt_addr      <= addr_d;
      tgt_write     <= write_d;
    end
  end

  assign loc_rsp_data = '0;

  logic unused_hi;
  assign unused_hi = ^{HI_W{1'b0}};
endmodule

// File: rtl/hr_router_chk.sv
module hr_router_chk #(
  parameter int HADDR_W = 36
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [HADDR_W-1:0] req_addr,
  input logic               req_write,
  input logic               tgt_valid,
  input logic [3:0]         tgt_sel,
  input logic [31:0]        tgt_addr,
  input logic               loc_rsp_valid
);
  logic hi;
  assign hi = |req_addr[HADDR_W-1:32];

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> tgt_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !tgt_valid);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> $countones(tgt_sel) == 1);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(tgt_sel) && $stable(tgt_addr)));
  p_claim_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hi) |=> (tgt_sel == 4'b1000 && tgt_addr == 32'h0));
  p_rd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hi && !req_write) |=> loc_rsp_valid);
  p_wr_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hi && req_write) |=> !loc_rsp_valid);
  p_rsp_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_rsp_valid |-> (tgt_valid && tgt_sel[3]));
  p_fwd_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hi) |=> tgt_addr == $past(req_addr[31:0]));
  p_conv_dram_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr < HADDR_W'(32'hA0000)) |=> tgt_sel == 4'b0001);
endmodule

bind host_addr_router hr_router_chk #(.HADDR_W(HADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_write     (req_write),
  .tgt_valid     (tgt_valid),
  .tgt_sel       (tgt_sel),
  .tgt_addr      (tgt_addr),
  .loc_rsp_valid (loc_rsp_valid)
);

// File: tb/host_addr_router_tb.sv
`timescale 1ns/1ps
module host_addr_router_tb;
  localparam logic [3:0] S_DRAM = 4'b0001, S_GFX = 4'b0010,
                         S_HUB  = 4'b0100, S_LOC = 4'b1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [35:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        tgt_valid, tgt_write, loc_rsp_valid;
  logic [3:0]  tgt_sel;
  logic [31:0] tgt_addr;
  logic [63:0] loc_rsp_data;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  host_addr_router u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tgt_valid(tgt_valid), .tgt_sel(tgt_sel),
    .tgt_addr(tgt_addr), .tgt_write(tgt_write),
    .loc_rsp_valid(loc_rsp_valid), .loc_rsp_data(loc_rsp_data)
  );

  task automatic cfg_write(input logic [2:0] s, input logic [31:0] d, input logic we);
    @(negedge clk);
    cfg_we = we; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_result(input logic [35:0] a, input logic w,
                               input logic [3:0] es, input string req);
    logic [31:0] ea;
    logic        er;
    ea = (es == S_LOC) ? 32'h0 : a[31:0];
    er = (es == S_LOC) && !w;
    checks++;
    if (tgt_valid !== 1'b1 || tgt_sel !== es || tgt_addr !== ea ||
        tgt_write !== w || loc_rsp_valid !== er ||
        (er && loc_rsp_data !== 64'h0)) begin
      failures++;
      $display("FAIL %s addr=%h wr=%0b: valid=%b sel=%b addr=%h wr=%b rsp=%b data=%h, expected valid=1 sel=%b addr=%h wr=%b rsp=%b data=0",
               req, a, w, tgt_valid, tgt_sel, tgt_addr, tgt_write,
               loc_rsp_valid, loc_rsp_data, es, ea, w, er);
    end
  endtask

  task automatic issue(input logic [35:0] a, input logic w,
                       input logic [3:0] es, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    expect_result(a, w, es, req);
  endtask

  task automatic t_reset;
    checks++;
    if (tgt_valid !== 1'b0 || loc_rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset outputs: valid=%b rsp=%b, expected 0 0", tgt_valid, loc_rsp_valid);
    end
    issue(36'h0_0010_0000, 1'b0, S_HUB, "R11 TOM reset 1MB");
    issue(36'h0_FFFF_FFFF, 1'b0, S_HUB, "R11 aperture empty at reset");
    issue(36'h0_000C_0000, 1'b0, S_HUB, "R11 segments disabled at reset");
    issue(36'h0_000A_0000, 1'b0, S_HUB, "R11 VGA to hub at reset");
  endtask

  task automatic t_conventional;
    issue(36'h0_0000_0000, 1'b0, S_DRAM, "R5 address zero");
    issue(36'h0_0009_FFFF, 1'b1, S_DRAM, "R5 top of conventional");
  endtask

  task automatic t_vga;
    issue(36'h0_000B_FFFF, 1'b0, S_HUB, "R6 VGA hub when bit clear");
    cfg_write(3'd3, 32'h1, 1'b1);
    issue(36'h0_000A_0000, 1'b0, S_GFX, "R6 VGA low edge to gfx");
    issue(36'h0_000B_FFFF, 1'b1, S_GFX, "R6 VGA high edge to gfx");
    issue(36'h0_0009_FFFF, 1'b0, S_DRAM, "R6 below VGA stays DRAM");
    issue(36'h0_000C_0000, 1'b0, S_HUB, "R6 above VGA not gfx");
  endtask

  task automatic t_segments;
    // seg0=01, seg1=10, seg2=11, seg3=00, seg15=11
    cfg_write(3'd4, 32'hC000_0039, 1'b1);
    issue(36'h0_000C_0000, 1'b0, S_DRAM, "R7 read-only seg read");
    issue(36'h0_000C_3FFF, 1'b1, S_HUB,  "R7 read-only seg write");
    issue(36'h0_000C_4000, 1'b0, S_HUB,  "R7 write-only seg read");
    issue(36'h0_000C_4000, 1'b1, S_DRAM, "R7 write-only seg write");
    issue(36'h0_000C_8000, 1'b0, S_DRAM, "R7 read/write seg read");
    issue(36'h0_000C_BFFF, 1'b1, S_DRAM, "R7 read/write seg write");
    issue(36'h0_000C_C000, 1'b0, S_HUB,  "R7 disabled seg read");
    issue(36'h0_000C_C000, 1'b1, S_HUB,  "R7 disabled seg write");
    issue(36'h0_000F_FFFF, 1'b1, S_DRAM, "R7 last seg write");
  endtask

  task automatic t_tom;
    cfg_write(3'd0, 32'h2000_0000, 1'b1);
    issue(36'h0_0010_0000, 1'b0, S_DRAM, "R8 1MB to DRAM");
    issue(36'h0_1FFF_FFFF, 1'b1, S_DRAM, "R8 TOM-1 to DRAM");
    issue(36'h0_2000_0000, 1'b0, S_HUB,  "R8 TOM to hub");
  endtask

  task automatic t_aperture;
    cfg_write(3'd1, 32'hE000_0000, 1'b1);
    cfg_write(3'd2, 32'hEFFF_FFFF, 1'b1);
    issue(36'h0_DFFF_FFFF, 1'b0, S_HUB, "R9 below base");
    issue(36'h0_E000_0000, 1'b0, S_GFX, "R9 base");
    issue(36'h0_EFFF_FFFF, 1'b1, S_GFX, "R9 limit");
    issue(36'h0_F000_0000, 1'b0, S_HUB, "R9 above limit");
  endtask

  task automatic t_above_4g;
    issue(36'h1_0000_0000, 1'b0, S_LOC, "R2 R3 4GB read zero data");
    issue(36'h1_0000_0000, 1'b1, S_LOC, "R3 4GB write dropped");
    issue(36'h1_0000_0005, 1'b0, S_LOC, "R2 low bits in DRAM");
    issue(36'hF_FFFF_FFFF, 1'b1, S_LOC, "R2 top of host space");
  endtask

  task automatic t_pipeline;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 36'h0_0000_1000; req_write = 1'b0;
    @(negedge clk);
    req_addr = 36'h0_E000_0040; req_write = 1'b1;
    expect_result(36'h0_0000_1000, 1'b0, S_DRAM, "R1 R4 back-to-back first");
    @(negedge clk);
    req_valid = 1'b0; req_addr = 36'h1_0000_0000;
    expect_result(36'h0_E000_0040, 1'b1, S_GFX, "R1 R4 back-to-back second");
    repeat (3) @(negedge clk);
    checks++;
    if (tgt_valid !== 1'b0 || tgt_sel !== S_GFX || tgt_addr !== 32'hE000_0040) begin
      failures++;
      $display("FAIL R1 idle hold: valid=%b sel=%b addr=%h, expected 0 %b e0000040",
               tgt_valid, tgt_sel, tgt_addr, S_GFX);
    end
  endtask

  task automatic t_ignored_cfg;
    cfg_write(3'd5, 32'h0, 1'b1);
    cfg_write(3'd7, 32'h0, 1'b1);
    cfg_write(3'd0, 32'h0, 1'b0);
    issue(36'h0_1FFF_FFFF, 1'b0, S_DRAM, "R10 unused selects and we=0 ignored");
    issue(36'h0_E000_0000, 1'b0, S_GFX,  "R10 aperture kept");
    cfg_write(3'd0, 32'h0010_0000, 1'b1);
    issue(36'h0_0010_0000, 1'b0, S_HUB,  "R10 TOM rewrite applies");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_conventional();
    t_vga();
    t_segments();
    t_tom();
    t_aperture();
    t_above_4g();
    t_pipeline();
    t_ignored_cfg();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule